// File: doc/BRIEF.md
# Broadcast TLB Invalidation Unit

This block executes a privileged fence instruction that removes cached address translations from every hart in a small cluster at once. It decodes the 32-bit instruction word. It checks the current privilege level and turns the two source operand values into an invalidation message. The message holds a virtual page number, an address-space identifier and two "match everything" flags, one for each field. The message goes out to the tag arrays of all harts in the same cycle. Each array clears every entry whose page number and identifier both satisfy the message.

A zero operand widens the match on its own field only. A zero address operand hits every page, a zero identifier operand hits every address space, and both zero flush everything. A request from user privilege is refused with a one-cycle illegal-instruction pulse. The per-hart tag arrays are held inside the block. A fill port writes single entries, and a flat vector of entry valid bits shows the arrays' state.

Top module: `tlb_bcast_inval`

## Requirements
- R1: A request is recognised only when instr[6:0]=0x0B, instr[11:7]=0, instr[14:12]=0 and instr[31:25]=0x02. Any other word has no effect: no strobe, no illegal pulse, no entry change.
- R2: A recognised request at privilege code 2'b00 (user) gives illegal_o=1 for exactly the one cycle after the accepting edge. It sends no strobe and changes no entry.
- R3: A recognised request at any other privilege code (2'b01 supervisor, 2'b11 machine, 2'b10 treated as non-user) drives hart_inval_o to all ones for exactly the one cycle after the accepting edge. It raises no illegal pulse.
- R4: An entry is cleared only when both its VPN and its ASID match the message. The message VPN is rs1[PAGE_BITS+VPN_W-1:PAGE_BITS], so page-offset bits are ignored. The message ASID is rs2[ASID_W-1:0].
- R5: rs1 equal to zero makes the page comparison match every entry. A nonzero rs1 whose VPN field is zero compares against VPN 0.
- R6: rs2 equal to zero makes the ASID comparison match every entry. A nonzero rs2 whose low ASID_W bits are zero compares against ASID 0.
- R7: With both operands zero, every entry of every hart is invalid after the clearing edge.
- R8: Matching entries in all harts are cleared on the same clock edge.
- R9: Entries clear at the edge that ends the strobe cycle. done_o pulses for the following cycle, and busy_o is high in both the strobe and done cycles. A request seen while busy_o is high is ignored completely, including for an illegal pulse.
- R10: fill_en_i writes entry fill_idx_i of hart fill_hart_i as valid with the given VPN and ASID. The write is visible at entry_valid_o bit fill_hart_i*DEPTH+fill_idx_i in the next cycle.
- R11: A fill landing on the clearing edge is compared against the message using its new contents. It ends invalid if it matches and valid otherwise.
- R12: Synchronous reset clears busy_o, done_o, illegal_o, hart_inval_o and all entry valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Instruction presented this cycle |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | XLEN | Address operand value |
| rs2_val_i | input | XLEN | Address-space identifier operand value |
| priv_i | input | 2 | Current privilege (00 user, 01 supervisor, 11 machine) |
| fill_en_i | input | 1 | Entry write strobe |
| fill_hart_i | input | HART_W | Hart selected for the write |
| fill_idx_i | input | IDX_W | Entry index for the write |
| fill_vpn_i | input | VPN_W | Page number written |
| fill_asid_i | input | ASID_W | Identifier written |
| busy_o | output | 1 | Invalidation in flight, new requests ignored |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle illegal-instruction pulse |
| hart_inval_o | output | HARTS | Per-hart invalidate strobes |
| entry_valid_o | output | HARTS*DEPTH | Valid bit of each entry, hart-major |

## Verification
Two functions can meet on one edge. The first is a fill into a tag array and the clearing sweep driven by a broadcast message. The second is a fresh request and the tail of a previous invalidation. The bench provokes the first by raising the fill strobe in exactly the strobe cycle, once with page and identifier that match the message and once with values that do not. It then judges the written entry's valid bit against the reference model: cleared in the first case, kept in the second. The second is provoked by holding the request line high through the busy window, including a switch to user privilege. The model then expects the second instruction to take effect only after done and never to raise a spurious illegal pulse.

// File: rtl/tlbi_pkg.sv
package tlbi_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  // fixed fields of the broadcast fence: opcode, rd, funct3, funct7
  localparam logic [31:0] FENCE_MASK  = 32'hFE00_7FFF;
  localparam logic [31:0] FENCE_MATCH = 32'h0400_000B;

endpackage

// File: rtl/tlbi_decode.sv
module tlbi_decode
  import tlbi_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int VPN_W     = 27,
  parameter int ASID_W    = 16,
  parameter int PAGE_BITS = 12
) (
  input  logic [31:0]       instr_i,
  input  logic [XLEN-1:0]   rs1_i,
  input  logic [XLEN-1:0]   rs2_i,
  input  logic [1:0]        priv_i,
  output logic              is_fence_o,
  output logic              is_user_o,
  output logic              va_all_o,
  output logic              asid_all_o,
  output logic [VPN_W-1:0]  vpn_o,
  output logic [ASID_W-1:0] asid_o
);

  always_comb begin
    is_fence_o = ((instr_i & FENCE_MASK) == FENCE_MATCH);
    is_user_o  = (priv_i == PRIV_U);
    va_all_o   = (rs1_i == '0);
    asid_all_o = (rs2_i == '0);
    vpn_o      = rs1_i[PAGE_BITS +: VPN_W];
    asid_o     = rs2_i[ASID_W-1:0];
  end

endmodule

// File: rtl/tlbi_ctrl.sv
module tlbi_ctrl #(
  parameter int HARTS  = 4,
  parameter int VPN_W  = 27,
  parameter int ASID_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              is_fence_i,
  input  logic              is_user_i,
  input  logic              va_all_i,
  input  logic              asid_all_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic [HARTS-1:0]  strobe_o,
  output logic              msg_va_all_o,
  output logic              msg_asid_all_o,
  output logic [VPN_W-1:0]  msg_vpn_o,
  output logic [ASID_W-1:0] msg_asid_o
);

  logic take, accept, trap, strobe_any;

  always_comb begin
    take       = req_valid_i && !busy_o && is_fence_i;
    accept     = take && !is_user_i;
    trap       = take && is_user_i;
    strobe_any = |strobe_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      strobe_o  <= '0;
    end else begin
      busy_o    <= accept || strobe_any;
      done_o    <= strobe_any;
      illegal_o <= trap;
      strobe_o  <= {HARTS{accept}};
    end
  end

  // message staging: no reset needed, only read while strobing
  always_ff @(posedge clk) begin
    if (accept) begin
      msg_va_all_o   <= va_all_i;
      msg_asid_all_o <= asid_all_i;
      msg_vpn_o      <= vpn_i;
      msg_asid_o     <= asid_i;
    end
  end

  p_done_after_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    strobe_any |=> (done_o && !(|strobe_o)));

  p_busy_covers_done_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> busy_o);

  p_illegal_excl_r2: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !strobe_any);

  p_illegal_user_r2: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> $past(is_user_i));

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> !illegal_o);

endmodule

// File: rtl/tlbi_hart_tlb.sv
module tlbi_hart_tlb #(
  parameter int DEPTH  = 8,
  parameter int VPN_W  = 27,
  parameter int ASID_W = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              inval_en_i,
  input  logic              va_all_i,
  input  logic              asid_all_i,
  input  logic [VPN_W-1:0]  inv_vpn_i,
  input  logic [ASID_W-1:0] inv_asid_i,
  output logic [DEPTH-1:0]  valid_o
);

  logic [VPN_W-1:0]  vpn_q  [DEPTH];
  logic [ASID_W-1:0] asid_q [DEPTH];
  logic [DEPTH-1:0]  valid_d;

  // tag storage: single write port, no reset
  always_ff @(posedge clk) begin
    if (fill_en_i) begin
      vpn_q[fill_idx_i]  <= fill_vpn_i;
      asid_q[fill_idx_i] <= fill_asid_i;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic              wr_here;
    logic [VPN_W-1:0]  cur_vpn;
    logic [ASID_W-1:0] cur_asid;
    logic              hit;
    always_comb begin
      wr_here  = fill_en_i && (fill_idx_i == IDX_W'(i));
      cur_vpn  = wr_here ? fill_vpn_i  : vpn_q[i];
      cur_asid = wr_here ? fill_asid_i : asid_q[i];
      hit      = inval_en_i
                 && (va_all_i   || (cur_vpn  == inv_vpn_i))
                 && (asid_all_i || (cur_asid == inv_asid_i));
      valid_d[i] = (wr_here || valid_o[i]) && !hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) valid_o <= '0;
    else     valid_o <= valid_d;
  end

  p_full_flush_r7: assert property (@(posedge clk) disable iff (rst)
    (inval_en_i && va_all_i && asid_all_i) |=> (valid_o == '0));

  p_fill_sets_r10: assert property (@(posedge clk) disable iff (rst)
    (fill_en_i && !inval_en_i) |=> valid_o[$past(fill_idx_i)]);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!fill_en_i && !inval_en_i) |=> $stable(valid_o));

endmodule

// File: rtl/tlb_bcast_inval.sv
module tlb_bcast_inval #(
  parameter int HARTS     = 4,
  parameter int DEPTH     = 8,
  parameter int XLEN      = 64,
  parameter int VPN_W     = 27,
  parameter int ASID_W    = 16,
  parameter int PAGE_BITS = 12,
  localparam int HART_W   = (HARTS > 1) ? $clog2(HARTS) : 1,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid_i,
  input  logic [31:0]            instr_i,
  input  logic [XLEN-1:0]        rs1_val_i,
  input  logic [XLEN-1:0]        rs2_val_i,
  input  logic [1:0]             priv_i,
  input  logic                   fill_en_i,
  input  logic [HART_W-1:0]      fill_hart_i,
  input  logic [IDX_W-1:0]       fill_idx_i,
  input  logic [VPN_W-1:0]       fill_vpn_i,
  input  logic [ASID_W-1:0]      fill_asid_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   illegal_o,
  output logic [HARTS-1:0]       hart_inval_o,
  output logic [HARTS*DEPTH-1:0] entry_valid_o
);

  logic              dec_fence, dec_user, dec_va_all, dec_asid_all;
  logic [VPN_W-1:0]  dec_vpn;
  logic [ASID_W-1:0] dec_asid;
  logic              m_va_all, m_asid_all;
  logic [VPN_W-1:0]  m_vpn;
  logic [ASID_W-1:0] m_asid;

  tlbi_decode #(
    .XLEN(XLEN), .VPN_W(VPN_W), .ASID_W(ASID_W), .PAGE_BITS(PAGE_BITS)
  ) u_dec (
    .instr_i    (instr_i),
    .rs1_i      (rs1_val_i),
    .rs2_i      (rs2_val_i),
    .priv_i     (priv_i),
    .is_fence_o (dec_fence),
    .is_user_o  (dec_user),
    .va_all_o   (dec_va_all),
    .asid_all_o (dec_asid_all),
    .vpn_o      (dec_vpn),
    .asid_o     (dec_asid)
  );

  tlbi_ctrl #(
    .HARTS(HARTS), .VPN_W(VPN_W), .ASID_W(ASID_W)
  ) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .req_valid_i    (req_valid_i),
    .is_fence_i     (dec_fence),
    .is_user_i      (dec_user),
    .va_all_i       (dec_va_all),
    .asid_all_i     (dec_asid_all),
    .vpn_i          (dec_vpn),
    .asid_i         (dec_asid),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .illegal_o      (illegal_o),
    .strobe_o       (hart_inval_o),
    .msg_va_all_o   (m_va_all),
    .msg_asid_all_o (m_asid_all),
    .msg_vpn_o      (m_vpn),
    .msg_asid_o     (m_asid)
  );

  for (genvar h = 0; h < HARTS; h++) begin : g_hart
    logic fill_sel;
    assign fill_sel = fill_en_i && (fill_hart_i == HART_W'(h));

    tlbi_hart_tlb #(
      .DEPTH(DEPTH), .VPN_W(VPN_W), .ASID_W(ASID_W)
    ) u_tlb (
      .clk         (clk),
      .rst         (rst),
      .fill_en_i   (fill_sel),
      .fill_idx_i  (fill_idx_i),
      .fill_vpn_i  (fill_vpn_i),
      .fill_asid_i (fill_asid_i),
      .inval_en_i  (hart_inval_o[h]),
      .va_all_i    (m_va_all),
      .asid_all_i  (m_asid_all),
      .inv_vpn_i   (m_vpn),
      .inv_asid_i  (m_asid),
      .valid_o     (entry_valid_o[h*DEPTH +: DEPTH])
    );
  end

endmodule

// File: tb/tlb_bcast_inval_test.sv
`timescale 1ns/1ps
module tlb_bcast_inval_test;

  localparam int HARTS = 4, DEPTH = 8, XLEN = 64, VPN_W = 27, ASID_W = 16, PB = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic req = 1'b0;
  logic [31:0] instr = '0;
  logic [XLEN-1:0] rs1 = '0, rs2 = '0;
  logic [1:0] priv = 2'b11;
  logic fill_en = 1'b0;
  logic [1:0] fill_hart = '0;
  logic [2:0] fill_idx = '0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [ASID_W-1:0] fill_asid = '0;
  logic busy, done, illegal;
  logic [HARTS-1:0] hinv;
  logic [HARTS*DEPTH-1:0] evalid;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  string phase = "R12";

  always #4 clk = ~clk;

  tlb_bcast_inval #(.HARTS(HARTS), .DEPTH(DEPTH), .XLEN(XLEN), .VPN_W(VPN_W),
                    .ASID_W(ASID_W), .PAGE_BITS(PB)) uut (
    .clk(clk), .rst(rst), .req_valid_i(req), .instr_i(instr),
    .rs1_val_i(rs1), .rs2_val_i(rs2), .priv_i(priv),
    .fill_en_i(fill_en), .fill_hart_i(fill_hart), .fill_idx_i(fill_idx),
    .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid),
    .busy_o(busy), .done_o(done), .illegal_o(illegal),
    .hart_inval_o(hinv), .entry_valid_o(evalid));

  // reference model state
  bit               r_v    [HARTS][DEPTH];
  logic [VPN_W-1:0] r_vpn  [HARTS][DEPTH];
  logic [ASID_W-1:0] r_asid[HARTS][DEPTH];
  bit m_busy, m_done, m_ill, m_strobe, m_vall, m_aall;
  logic [VPN_W-1:0] m_vpn;
  logic [ASID_W-1:0] m_asid;

  function automatic logic [31:0] enc(input logic [4:0] a, input logic [4:0] b);
    return {7'h02, b, a, 3'b000, 5'b00000, 7'h0B};
  endfunction

  always @(posedge clk) begin : model
    bit enc_ok, acc, ill, here;
    if (rst) begin
      m_busy = 0; m_done = 0; m_ill = 0; m_strobe = 0;
      for (int h = 0; h < HARTS; h++) for (int i = 0; i < DEPTH; i++) r_v[h][i] = 0;
    end else begin
      enc_ok = (instr[6:0] == 7'h0B) && (instr[11:7] == 5'd0) &&
               (instr[14:12] == 3'd0) && (instr[31:25] == 7'h02);
      acc = req && !m_busy && enc_ok && (priv != 2'b00);
      ill = req && !m_busy && enc_ok && (priv == 2'b00);
      for (int h = 0; h < HARTS; h++) begin
        for (int i = 0; i < DEPTH; i++) begin
          here = fill_en && (int'(fill_hart) == h) && (int'(fill_idx) == i);
          if (here) begin
            r_v[h][i] = 1; r_vpn[h][i] = fill_vpn; r_asid[h][i] = fill_asid;
          end
          if (m_strobe && (m_vall || r_vpn[h][i] == m_vpn) &&
              (m_aall || r_asid[h][i] == m_asid))
            r_v[h][i] = 0;
        end
      end
      m_done = m_strobe;
      m_busy = acc || m_strobe;
      m_strobe = acc;
      m_ill = ill;
      if (acc) begin
        m_vall = (rs1 == '0); m_aall = (rs2 == '0);
        m_vpn = rs1[PB +: VPN_W]; m_asid = rs2[ASID_W-1:0];
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    logic [HARTS*DEPTH-1:0] ev;
    if (!rst && !finished) begin
      for (int h = 0; h < HARTS; h++)
        for (int i = 0; i < DEPTH; i++) ev[h*DEPTH+i] = r_v[h][i];
      chk({phase, " illegal R2"}, 64'(illegal), 64'(m_ill));
      chk({phase, " strobe R3 R8"}, 64'(hinv), m_strobe ? 64'hF : 64'h0);
      chk({phase, " done R9"}, 64'(done), 64'(m_done));
      chk({phase, " busy R9"}, 64'(busy), 64'(m_busy));
      chk({phase, " entries"}, 64'(evalid), 64'(ev));
    end
  end

  task automatic fill(input int h, input int i, input logic [VPN_W-1:0] v,
                      input logic [ASID_W-1:0] a);
    @(negedge clk);
    fill_en = 1; fill_hart = 2'(h); fill_idx = 3'(i); fill_vpn = v; fill_asid = a;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic fill_all();
    for (int h = 0; h < HARTS; h++)
      for (int i = 0; i < DEPTH; i++)
        fill(h, i, 27'h100 + 27'(i), i[0] ? 16'd5 : 16'd7);
  endtask

  task automatic issue(input logic [31:0] w, input logic [XLEN-1:0] a,
                       input logic [XLEN-1:0] b, input logic [1:0] p);
    @(negedge clk);
    req = 1; instr = w; rs1 = a; rs2 = b; priv = p;
    @(negedge clk);
    req = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic issue_race(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                            input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] s);
    @(negedge clk);
    req = 1; instr = enc(5'd1, 5'd2); rs1 = a; rs2 = b; priv = 2'b01;
    @(negedge clk);
    req = 0;
    fill_en = 1; fill_hart = 2'd0; fill_idx = 3'd2; fill_vpn = v; fill_asid = s;
    @(negedge clk);
    fill_en = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R9 actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: outputs during reset
    chk("R12 busy", 64'(busy), 0);
    chk("R12 done", 64'(done), 0);
    chk("R12 illegal", 64'(illegal), 0);
    chk("R12 strobe", 64'(hinv), 0);
    chk("R12 entries", 64'(evalid), 0);
    rst = 0;

    phase = "R10"; fill_all();
    chk("R10 all filled", 64'(evalid), 64'hFFFF_FFFF);

    phase = "R4 R8";  // VPN 0x101 with offset bits, ASID 5: index 1 in every hart
    issue(enc(5'd3, 5'd4), (64'h101 << PB) | 64'hABC, 64'd5, 2'b01);
    chk("R4 index1 cleared", 64'(evalid), 64'hFDFD_FDFD);
    issue(enc(5'd3, 5'd4), 64'h102 << PB, 64'd5, 2'b11);  // ASID mismatch
    chk("R4 asid mismatch kept", 64'(evalid), 64'hFDFD_FDFD);

    phase = "R2";
    issue(enc(5'd3, 5'd4), 64'h103 << PB, 64'd5, 2'b00);

    phase = "R1";
    issue(enc(5'd1, 5'd2) ^ 32'h0200_0000, 64'd0, 64'd0, 2'b11);
    issue(enc(5'd1, 5'd2) ^ 32'h0000_0004, 64'd0, 64'd0, 2'b11);
    issue(enc(5'd1, 5'd2) | 32'h0000_1000, 64'd0, 64'd0, 2'b11);
    issue(enc(5'd1, 5'd2) | 32'h0000_0080, 64'd0, 64'd0, 2'b00);
    chk("R1 unchanged", 64'(evalid), 64'hFDFD_FDFD);

    phase = "R5";
    fill_all();
    issue(enc(5'd0, 5'd9), 64'd0, 64'd7, 2'b01);  // all pages, ASID 7: even indices
    fill(2, 3, 27'h0, 16'd9);
    issue(enc(5'd5, 5'd6), 64'h123, 64'd9, 2'b11);  // VPN 0 only

    phase = "R6";
    fill_all();
    issue(enc(5'd5, 5'd0), 64'h104 << PB, 64'd0, 2'b01);
    fill(1, 6, 27'h200, 16'd0);
    issue(enc(5'd5, 5'd6), 64'h200 << PB, 64'h1_0000, 2'b01);

    phase = "R9";  // request held high across the busy window
    fill_all();
    @(negedge clk);
    req = 1; instr = enc(5'd1, 5'd2); rs1 = 64'h101 << PB; rs2 = 64'd5; priv = 2'b10;
    @(negedge clk); priv = 2'b00;
    repeat (3) @(negedge clk);
    req = 0;
    repeat (3) @(negedge clk);
    @(negedge clk);
    req = 1; rs1 = '0; rs2 = 64'd5; priv = 2'b01;
    repeat (6) @(negedge clk);
    req = 0;
    repeat (3) @(negedge clk);

    phase = "R11";
    fill_all();
    issue_race(64'h105 << PB, 64'd0, 27'h105, 16'd3);
    chk("R11 matching fill cleared", 64'(evalid[2]), 0);
    fill_all();
    issue_race(64'h105 << PB, 64'd0, 27'h1FF, 16'd3);
    chk("R11 non-matching fill kept", 64'(evalid[2]), 1);

    phase = "R7";
    fill_all();
    issue(enc(5'd0, 5'd0), 64'd0, 64'd0, 2'b11);
    chk("R7 all invalid", 64'(evalid), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule